// File: doc/BRIEF.md
# Serial Master Clock Divider

This block produces the serial clock for a synchronous serial master that can run as an I2C controller or as an SPI master. An 8-bit divider value sets the clock speed. A down counter runs on an enable that fires once every two system clocks. When the counter reaches zero and the next enable arrives, the counter reloads from the divider value and the clock line flips. Because the clock flips on every rollover, one full clock period is four times (divider + 1) system clocks.

A write strobe to the transmit buffer starts the clock. A transfer-complete strobe stops it, and the line then keeps whatever level it had at that moment. In I2C mode the divider must be at least 3. A smaller value raises a sticky configuration error, and the write does not start the clock. While the I2C clock is high, an external hold input can delay the next rollover, so that a slow device can stretch the clock. Every rollover also produces a one-cycle pulse, which a shift register can use as its shift or sample strobe.

Top module: `sclk_rate_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `running`, `cfg_err` and `roll_pulse`. It drives `sclk_out` to the idle level: 1 when `mode_sel` is 4'b1000 (I2C), `spi_cpol` when `mode_sel` is 4'b00xx (SPI), and 1 for any other mode value.
- R2: A `buf_wr` pulse while idle, in a supported mode and with an accepted divider value, sets `running` at the next edge. The first change of `sclk_out` then occurs 2*(reload_val+1) clock cycles after that edge.
- R3: Each later half period lasts 2*(reload_val+1) cycles. `reload_val` is sampled at each rollover, so a new value takes effect at the rollover after the one that loads it.
- R4: `roll_pulse` is high for exactly one cycle, in the same cycle that `sclk_out` shows its new level. It is never high at any other time.
- R5: In I2C mode, a `buf_wr` with `reload_val` below 3 sets `cfg_err`, leaves `running` low and leaves `sclk_out` unchanged. `cfg_err` stays set until reset, including after a later accepted start.
- R6: In SPI mode, every divider value is accepted, including 0, which gives a half period of 2 cycles.
- R7: A `xfer_done` pulse while running clears `running` at the next edge. `sclk_out` then keeps its level and no `roll_pulse` occurs until the next start.
- R8: In I2C mode, while `sclk_out` is high and `hold_reload` is high, the rollover is deferred and `sclk_out` stays high. It flips within 2 cycles after `hold_reload` falls. In SPI mode, `hold_reload` has no effect.
- R9: A `buf_wr` while running is ignored and does not change the timing of the next clock edge.
- R10: A `buf_wr` is ignored when `mode_sel` is any value other than 4'b1000 or 4'b00xx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 4 | Mode field: 4'b1000 I2C, 4'b00xx SPI, others unsupported |
| spi_cpol | input | 1 | SPI idle clock level |
| reload_val | input | 8 | Divider value loaded at start and at each rollover |
| buf_wr | input | 1 | Transmit buffer write strobe; starts the clock |
| xfer_done | input | 1 | Operation-complete strobe; stops the clock |
| hold_reload | input | 1 | Delays the rollover while the I2C clock is high |
| sclk_out | output | 1 | Serial clock line |
| roll_pulse | output | 1 | One-cycle pulse at each rollover |
| running | output | 1 | Clock generation active |
| cfg_err | output | 1 | Sticky flag for a rejected I2C divider value |

## Verification
The assertions check on every cycle the properties that involve no counting:
- `sclk_out` only changes together with `roll_pulse`.
- The pulse is never two cycles long and never appears when the block was idle.
- The error flag is sticky, and a rejected I2C start leaves the block idle.
- A hold keeps a high I2C clock high, and a stop freezes the line.

Only the bench scenarios can show the timing that depends on counting. These are the 2*(reload+1) spacing of the edges, a new divider value taking effect one rollover late, a second write during a run leaving that spacing intact, and the idle levels after reset in each mode.

// File: rtl/sbrg_pkg.sv
package sbrg_pkg;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_SPI,
        MODE_I2C
    } mode_e;

    // Control state held between edges
    typedef struct packed {
        logic running;
        logic sclk;
        logic err;
        logic pulse;
    } ctrl_s;

    function automatic mode_e decode_mode(input logic [3:0] sel);
        if (sel == 4'b1000)
            return MODE_I2C;
        else if (sel[3:2] == 2'b00)
            return MODE_SPI;
        else
            return MODE_OFF;
    endfunction

endpackage

// File: rtl/sbrg_prescale.sv
module sbrg_prescale #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_div
            localparam int unsigned PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);

            logic [PW-1:0] ph_d, ph_q;

            always_comb begin
                ph_d = ph_q;
                if (!run || ph_q == LAST)
                    ph_d = '0;
                else
                    ph_d = ph_q + PW'(1);
            end

            always_ff @(posedge clk) begin
                if (rst)
                    ph_q <= '0;
                else
                    ph_q <= ph_d;
            end

            assign tick = run && (ph_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/sbrg_downcnt.sv
module sbrg_downcnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         allow,
    input  logic         stop,
    output logic         rollover
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        rollover = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && !stop) begin
            if (cnt_q == '0) begin
                if (allow) begin
                    cnt_d    = load_val;
                    rollover = 1'b1;
                end
            end else begin
                cnt_d = cnt_q - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sbrg_ctrl.sv
module sbrg_ctrl
    import sbrg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  cpol,
    input  logic  buf_wr,
    input  logic  value_ok,
    input  logic  xfer_done,
    input  logic  rollover,
    output logic  start,
    output ctrl_s state
);
    ctrl_s st_d, st_q;
    logic  idle_lvl;
    logic  req;

    always_comb begin
        idle_lvl = (mode == MODE_SPI) ? cpol : 1'b1;
        req      = buf_wr && !st_q.running;
        start    = req && (mode != MODE_OFF) && ((mode != MODE_I2C) || value_ok);

        st_d       = st_q;
        st_d.pulse = rollover;
        if (rollover)
            st_d.sclk = ~st_q.sclk;
        if (req && mode == MODE_I2C && !value_ok)
            st_d.err = 1'b1;
        if (st_q.running && xfer_done)
            st_d.running = 1'b0;
        else if (start)
            st_d.running = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '{running: 1'b0, sclk: idle_lvl, err: 1'b0, pulse: 1'b0};
        else
            st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
    import sbrg_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned MIN_RELOAD = 3,
    parameter int unsigned PRESCALE   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       mode_sel,
    input  logic             spi_cpol,
    input  logic [WIDTH-1:0] reload_val,
    input  logic             buf_wr,
    input  logic             xfer_done,
    input  logic             hold_reload,
    output logic             sclk_out,
    output logic             roll_pulse,
    output logic             running,
    output logic             cfg_err
);
    localparam logic [WIDTH-1:0] MIN_V = WIDTH'(MIN_RELOAD);

    mode_e mode;
    ctrl_s state;
    logic  tick, start, rollover, allow, value_ok;

    always_comb begin
        mode     = decode_mode(mode_sel);
        value_ok = (reload_val >= MIN_V);
        allow    = !((mode == MODE_I2C) && state.sclk && hold_reload);
    end

    sbrg_prescale #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (state.running),
        .tick (tick)
    );

    sbrg_downcnt #(.W(WIDTH)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (reload_val),
        .tick     (tick),
        .allow    (allow),
        .stop     (xfer_done),
        .rollover (rollover)
    );

    sbrg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cpol      (spi_cpol),
        .buf_wr    (buf_wr),
        .value_ok  (value_ok),
        .xfer_done (xfer_done),
        .rollover  (rollover),
        .start     (start),
        .state     (state)
    );

    assign sclk_out   = state.sclk;
    assign roll_pulse = state.pulse;
    assign running    = state.running;
    assign cfg_err    = state.err;
endmodule

// File: rtl/sbrg_checker.sv
module sbrg_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] mode_sel,
    input logic [7:0] reload_val,
    input logic       buf_wr,
    input logic       xfer_done,
    input logic       hold_reload,
    input logic       sclk_out,
    input logic       roll_pulse,
    input logic       running,
    input logic       cfg_err
);
    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= !rst;

    logic i2c;
    assign i2c = (mode_sel == 4'b1000);

    p_edge_with_pulse_r4: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$stable(sclk_out) |-> roll_pulse);

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst || !armed_q)
        roll_pulse |=> !roll_pulse);

    p_pulse_needs_run_r7: assert property (@(posedge clk) disable iff (rst || !armed_q)
        roll_pulse |-> $past(running));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(cfg_err) |-> cfg_err);

    p_reject_small_r5: assert property (@(posedge clk) disable iff (rst)
        (i2c && buf_wr && !running && reload_val < 8'd3) |=> (!running && cfg_err));

    p_hold_high_r8: assert property (@(posedge clk) disable iff (rst)
        (i2c && running && sclk_out && hold_reload) |=> sclk_out);

    p_stop_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (running && xfer_done) |=> (!running && $stable(sclk_out)));
endmodule

bind sclk_rate_gen sbrg_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_sel    (mode_sel),
    .reload_val  (reload_val),
    .buf_wr      (buf_wr),
    .xfer_done   (xfer_done),
    .hold_reload (hold_reload),
    .sclk_out    (sclk_out),
    .roll_pulse  (roll_pulse),
    .running     (running),
    .cfg_err     (cfg_err)
);

// File: tb/sclk_rate_gen_test.sv
module sclk_rate_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mode_sel = 4'b1000;
    logic       spi_cpol = 1'b0;
    logic [7:0] reload_val = 8'd3;
    logic       buf_wr = 1'b0;
    logic       xfer_done = 1'b0;
    logic       hold_reload = 1'b0;
    logic       sclk_out, roll_pulse, running, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sclk_rate_gen uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .spi_cpol(spi_cpol),
        .reload_val(reload_val), .buf_wr(buf_wr), .xfer_done(xfer_done),
        .hold_reload(hold_reload), .sclk_out(sclk_out), .roll_pulse(roll_pulse),
        .running(running), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] m, input logic pol);
        @(negedge clk);
        mode_sel = m; spi_cpol = pol; rst = 1'b1;
        buf_wr = 1'b0; xfer_done = 1'b0; hold_reload = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic start_wr();
        buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    task automatic wait_toggle(output int n, output int p_at, output int p_extra);
        logic s0;
        s0 = sclk_out; n = 0; p_at = 0; p_extra = 0;
        while (n < 300) begin
            @(negedge clk);
            n++;
            if (sclk_out != s0) begin
                p_at = int'(roll_pulse);
                break;
            end
            if (roll_pulse) p_extra++;
        end
    endtask

    task automatic quiet_cycles(input int cycles, output int changes, output int pulses);
        logic s0;
        s0 = sclk_out; changes = 0; pulses = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sclk_out != s0) changes++;
            if (roll_pulse) pulses++;
            s0 = sclk_out;
        end
    endtask

    task automatic t_reset();
        do_reset(4'b1000, 1'b0);
        chk("R1 i2c idle sclk", int'(sclk_out), 1);
        chk("R1 running", int'(running), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
        chk("R1 roll_pulse", int'(roll_pulse), 0);
        do_reset(4'b0000, 1'b0);
        chk("R1 spi cpol0 idle", int'(sclk_out), 0);
        do_reset(4'b0001, 1'b1);
        chk("R1 spi cpol1 idle", int'(sclk_out), 1);
    endtask

    task automatic t_i2c_period();
        int n, pa, pe, ch, pu;
        do_reset(4'b1000, 1'b0);
        reload_val = 8'd3;
        start_wr();
        chk("R2 running after start", int'(running), 1);
        wait_toggle(n, pa, pe);
        chk("R2 first half period", n, 8);
        chk("R2 sclk low", int'(sclk_out), 0);
        chk("R4 pulse with edge", pa, 1);
        wait_toggle(n, pa, pe);
        chk("R3 second half period", n, 8);
        chk("R4 no stray pulse", pe, 0);
        reload_val = 8'd5;
        wait_toggle(n, pa, pe);
        chk("R3 old value still counted", n, 8);
        wait_toggle(n, pa, pe);
        chk("R3 new value half period", n, 12);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R7 running cleared", int'(running), 0);
        quiet_cycles(40, ch, pu);
        chk("R7 sclk held", ch, 0);
        chk("R7 no pulses", pu, 0);
    endtask

    task automatic t_i2c_invalid();
        do_reset(4'b1000, 1'b0);
        reload_val = 8'd2;
        start_wr();
        chk("R5 err on 2", int'(cfg_err), 1);
        chk("R5 no start on 2", int'(running), 0);
        chk("R5 sclk unchanged", int'(sclk_out), 1);
        reload_val = 8'd0;
        start_wr();
        chk("R5 no start on 0", int'(running), 0);
        reload_val = 8'd4;
        start_wr();
        chk("R5 valid start after err", int'(running), 1);
        chk("R5 err sticky", int'(cfg_err), 1);
    endtask

    task automatic t_spi_fast();
        int n, pa, pe;
        do_reset(4'b0000, 1'b1);
        reload_val = 8'd0;
        start_wr();
        chk("R6 spi start on 0", int'(running), 1);
        wait_toggle(n, pa, pe);
        chk("R6 half period 2", n, 2);
        chk("R6 sclk low", int'(sclk_out), 0);
        wait_toggle(n, pa, pe);
        chk("R6 next half period 2", n, 2);
        chk("R6 no err", int'(cfg_err), 0);
    endtask

    task automatic t_hold();
        int n, pa, pe, ch, pu;
        do_reset(4'b1000, 1'b0);
        reload_val = 8'd3;
        hold_reload = 1'b1;
        start_wr();
        quiet_cycles(30, ch, pu);
        chk("R8 held high", int'(sclk_out), 1);
        chk("R8 no edges while held", ch, 0);
        hold_reload = 1'b0;
        wait_toggle(n, pa, pe);
        chk("R8 resumes within 2", int'(n >= 1 && n <= 2), 1);
        do_reset(4'b0010, 1'b0);
        hold_reload = 1'b1;
        reload_val = 8'd3;
        start_wr();
        wait_toggle(n, pa, pe);
        chk("R8 spi ignores hold", n, 8);
        hold_reload = 1'b0;
    endtask

    task automatic t_rewrite();
        int n, pa, pe;
        do_reset(4'b1000, 1'b0);
        reload_val = 8'd3;
        start_wr();
        repeat (3) @(negedge clk);
        reload_val = 8'd10;
        start_wr();
        wait_toggle(n, pa, pe);
        chk("R9 timing unchanged", n, 4);
        chk("R9 still running", int'(running), 1);
    endtask

    task automatic t_bad_mode();
        int ch, pu;
        do_reset(4'b0100, 1'b0);
        reload_val = 8'd5;
        start_wr();
        chk("R10 mode 0100 ignored", int'(running), 0);
        quiet_cycles(20, ch, pu);
        chk("R10 no edges", ch, 0);
        do_reset(4'b1011, 1'b0);
        start_wr();
        chk("R10 mode 1011 ignored", int'(running), 0);
        chk("R10 no err", int'(cfg_err), 0);
    endtask

    initial begin
        t_reset();
        t_i2c_period();
        t_i2c_invalid();
        t_spi_fast();
        t_hold();
        t_rewrite();
        t_bad_mode();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule